// File: doc/BRIEF.md
# Diagonal Edge Detector

This block turns a raster stream of 6-bit pixel codes, 120 columns by 120 rows per frame, into a stream of one-bit edge flags. It keeps the two rows above the current one in line storage. For every interior pixel it forms two corner-to-corner differences across the 3×3 neighbourhood around that pixel. Each difference is judged by its magnitude against a selectable threshold. The pixel is flagged as an edge when either diagonal exceeds the threshold.

A second mode, chosen per frame, skips the mask and sends every accepted pixel code straight to the output. Both modes share one output port, which carries start-of-frame and end-of-line markers. The input accepts one pixel per clock whenever it is valid. The first pixel of a frame carries a start marker, and the mode and threshold selection are captured together with that pixel.

Top module: `diag_edge`

## Requirements
- R1: While rstN is low outValid is 0. From the first clock edge after reset is released, inReady is 1.
- R2: A pixel is accepted on a clock edge where inValid and inReady are both 1. Accepted pixels take raster positions (row, column). A pixel with inSof=1 takes position (0,0). After column WIDTH−1 the column returns to 0 and the row advances. After the last row the row returns to 0.
- R3: Image mode is selected with modeImage=1. Each accepted pixel appears unchanged on outData one clock after acceptance. outSof is 1 for position (0,0), and outEol is 1 for column WIDTH−1.
- R4: Edge mode is selected with modeImage=0. An accepted pixel at row r≥1 and column c≥1 produces exactly one output one clock later, for the centre (r−1, c−1). Any other accepted pixel produces no output. outSof marks centre (0,0) and outEol marks centre column WIDTH−2.
- R5: For centre (y,x), with P the pixel code, the block forms two differences: A = P(y−1,x−1) − P(y+1,x+1) and B = P(y−1,x+1) − P(y+1,x−1).
- R6: In edge mode, outData bit 0 is 1 exactly when |A| or |B| is above the threshold T. The magnitude is saturated to 5 bits before the comparison. Bits 5..1 of outData are 0.
- R7: T is 16, 8, 4 or 2 for thrSel values 0, 1, 2 and 3 respectively.
- R8: A magnitude equal to T does not count as an edge.
- R9: A centre in row 0 or column 0 always gives an edge flag of 0.
- R10: modeImage and thrSel are used only with the pixel that carries inSof. Changing them on any other pixel does not change the output.
- R11: A cycle with inValid=0 accepts nothing and produces no output in the following cycle. Stalls between pixels do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel is present |
| inReady | output | 1 | Block can take a pixel |
| inPixel | input | 6 | Pixel code |
| inSof | input | 1 | Pixel is the first of a frame |
| modeImage | input | 1 | 1 = pass pixel codes through, 0 = edge flags |
| thrSel | input | 2 | Threshold select |
| outValid | output | 1 | Output word is present |
| outData | output | 6 | Pixel code, or edge flag in bit 0 |
| outSof | output | 1 | Output is the first of its frame |
| outEol | output | 1 | Output is the last of its line |

## Verification
A ramp image in pass-through mode shows whether codes and markers stay aligned when the stream has random gaps. Random frames with all thresholds exercise both diagonals and the edge and border logic together. A uniform diagonal slope gives one difference of exactly 8 and the other of 0. This separates a strict comparison from an inclusive one, and it tells threshold settings 1 and 2 apart. An anti-diagonal slope gives only B a non-zero value, which exposes a swapped or missing second direction. Frames with random mode and threshold inputs on non-start pixels, restarts in the middle of a row, and one full frame followed by a wrap into the next frame without a start marker check when settings are captured and how the position counters behave.

// File: rtl/diag_edge_pkg.sv
package diag_edge_pkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic             push;      // pixel accepted this cycle
    logic             emit;      // an output word is produced
    logic             edgeMode;  // frame runs the diagonal mask
    logic             border;    // centre sits on row 0 or column 0
    logic             outSof;
    logic             outEol;
    logic [SEL_W-1:0] thrSel;    // threshold selection in force
  } ctrlStrobe_t;
endpackage

// File: rtl/diag_edge_ctrl.sv
module diag_edge_ctrl
  import diag_edge_pkg::*;
#(
  parameter int WIDTH  = 120,
  parameter int HEIGHT = 120,
  localparam int COL_W = $clog2(WIDTH),
  localparam int ROW_W = $clog2(HEIGHT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             modeImage,
  input  logic [SEL_W-1:0] thrSel,
  output logic             inReady,
  output logic [COL_W-1:0] colIdx,
  output ctrlStrobe_t      strobe
);
  logic [COL_W-1:0] colCnt, curCol;
  logic [ROW_W-1:0] rowCnt, curRow;
  logic             modeReg, curMode, readyReg, push;
  logic [SEL_W-1:0] selReg, curSel;

  always_comb begin
    push    = inValid && readyReg;
    curCol  = inSof ? '0 : colCnt;
    curRow  = inSof ? '0 : rowCnt;
    curMode = inSof ? modeImage : modeReg;
    curSel  = inSof ? thrSel : selReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt   <= '0;
      rowCnt   <= '0;
      modeReg  <= 1'b0;
      selReg   <= '0;
      readyReg <= 1'b0;
    end else begin
      readyReg <= 1'b1;
      if (push) begin
        if (curCol == COL_W'(WIDTH - 1)) begin
          colCnt <= '0;
          rowCnt <= (curRow == ROW_W'(HEIGHT - 1)) ? '0 : curRow + 1'b1;
        end else begin
          colCnt <= curCol + 1'b1;
          rowCnt <= curRow;
        end
        if (inSof) begin
          modeReg <= modeImage;
          selReg  <= thrSel;
        end
      end
    end
  end

  always_comb begin
    strobe.push     = push;
    strobe.emit     = push && (curMode || (curRow != '0 && curCol != '0));
    strobe.edgeMode = !curMode;
    strobe.border   = (curRow == ROW_W'(1)) || (curCol == COL_W'(1));
    strobe.outSof   = curMode ? (curRow == '0 && curCol == '0)
                              : (curRow == ROW_W'(1) && curCol == COL_W'(1));
    strobe.outEol   = (curCol == COL_W'(WIDTH - 1));
    strobe.thrSel   = curSel;
  end

  assign inReady = readyReg;
  assign colIdx  = curCol;

  a_r2_col_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(colCnt) < WIDTH);
  a_r2_row_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(rowCnt) < HEIGHT);
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(push && inSof) |=> $stable(modeReg) && $stable(selReg));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !push |=> $stable(colCnt) && $stable(rowCnt));
endmodule

// File: rtl/diag_edge_dp.sv
module diag_edge_dp
  import diag_edge_pkg::*;
#(
  parameter int WIDTH  = 120,
  parameter int PIX_W  = 6,
  parameter int MAG_W  = 5,
  localparam int COL_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [COL_W-1:0] colIdx,
  input  logic [PIX_W-1:0] inPixel,
  output logic             outValid,
  output logic             outSof,
  output logic             outEol,
  output logic [PIX_W-1:0] outData
);
  localparam int LINES   = 2;
  localparam int TOP_THR = 1 << (MAG_W - 1);
  localparam int MAG_MAX = (1 << MAG_W) - 1;
  localparam int DIF_W   = PIX_W + 1;

  // tap[0] is the incoming pixel, tap[k] is the same column k rows up
  logic [PIX_W-1:0] tap [LINES+1];
  assign tap[0] = inPixel;

  for (genvar i = 0; i < LINES; i++) begin : gLine
    logic [PIX_W-1:0] mem [WIDTH];
    assign tap[i+1] = mem[colIdx];
    always_ff @(posedge clk) begin
      if (strobe.push) mem[colIdx] <= tap[i];
    end
  end

  logic [PIX_W-1:0] topD1, topD2, botD1, botD2;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      topD1 <= '0; topD2 <= '0; botD1 <= '0; botD2 <= '0;
    end else if (strobe.push) begin
      topD1 <= tap[LINES];
      topD2 <= topD1;
      botD1 <= inPixel;
      botD2 <= botD1;
    end
  end

  function automatic logic [MAG_W-1:0] satMag(input logic [DIF_W-1:0] d);
    logic [DIF_W-1:0] a;
    a = d[DIF_W-1] ? (~d + 1'b1) : d;
    return (a > DIF_W'(MAG_MAX)) ? MAG_W'(MAG_MAX) : a[MAG_W-1:0];
  endfunction

  logic [DIF_W-1:0] diffA, diffB;
  logic [MAG_W-1:0] magA, magB, thr;
  logic             edgeFlag;

  always_comb begin
    diffA    = {1'b0, topD2} - {1'b0, inPixel};
    diffB    = {1'b0, tap[LINES]} - {1'b0, botD2};
    magA     = satMag(diffA);
    magB     = satMag(diffB);
    thr      = MAG_W'(TOP_THR >> strobe.thrSel);
    edgeFlag = !strobe.border && ((magA > thr) || (magB > thr));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outSof  <= strobe.outSof;
        outEol  <= strobe.outEol;
        outData <= strobe.edgeMode ? {{(PIX_W-1){1'b0}}, edgeFlag} : inPixel;
      end
    end
  end

  a_r4_emit_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> outValid);
  a_r11_no_emit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> !outValid);
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit && strobe.edgeMode |=> outData[PIX_W-1:1] == '0);
  a_r9_border_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit && strobe.edgeMode && strobe.border |=> outData == '0);
  a_r3_passthru: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit && !strobe.edgeMode |=> outData == $past(inPixel));
endmodule

// File: rtl/diag_edge.sv
module diag_edge
  import diag_edge_pkg::*;
#(
  parameter int WIDTH  = 120,
  parameter int HEIGHT = 120,
  parameter int PIX_W  = 6,
  parameter int MAG_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PIX_W-1:0] inPixel,
  input  logic             inSof,
  input  logic             modeImage,
  input  logic [SEL_W-1:0] thrSel,
  output logic             outValid,
  output logic [PIX_W-1:0] outData,
  output logic             outSof,
  output logic             outEol
);
  localparam int COL_W = $clog2(WIDTH);

  ctrlStrobe_t      strobe;
  logic [COL_W-1:0] colIdx;

  diag_edge_ctrl #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof),
    .modeImage(modeImage), .thrSel(thrSel), .inReady(inReady),
    .colIdx(colIdx), .strobe(strobe)
  );

  diag_edge_dp #(.WIDTH(WIDTH), .PIX_W(PIX_W), .MAG_W(MAG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .colIdx(colIdx),
    .inPixel(inPixel), .outValid(outValid), .outSof(outSof),
    .outEol(outEol), .outData(outData)
  );
endmodule

// File: tb/diag_edge_bench.sv
`timescale 1ns/1ps
module diag_edge_bench;
  localparam int W = 120, H = 120, PW = 6;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, inSof = 1'b0, modeImage = 1'b0;
  logic [1:0] thrSel = '0;
  logic [PW-1:0] inPixel = '0;
  logic inReady, outValid, outSof, outEol;
  logic [PW-1:0] outData;

  always #2 clk = ~clk;

  diag_edge #(.WIDTH(W), .HEIGHT(H), .PIX_W(PW)) u_diag_edge (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inPixel(inPixel), .inSof(inSof), .modeImage(modeImage), .thrSel(thrSel),
    .outValid(outValid), .outData(outData), .outSof(outSof), .outEol(outEol)
  );

  int vecCount = 0, failCount = 0;
  bit done = 0;
  string tag = "R1";
  int ring [3][W];
  int mRow = 0, mCol = 0, mMode = 0, mThr = 16;
  bit expValid = 0, expSof = 0, expEol = 0;
  logic [PW-1:0] expData = '0;
  int unsigned lfsr = 32'h1ACE5EED;

  function automatic int nextRand();
    lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
    return int'(lfsr & 32'h7fffffff);
  endfunction

  function automatic int pattern(int kind, int r, int c);
    case (kind)
      0: return nextRand() & 63;
      1: return (2 * (r + c)) & 63;          // A = -8, B = 0
      2: return (3 * c - 3 * r + 192) & 63;  // A = 0,  B = 12
      3: return (7 * r + c) & 63;
      default: return (c < 60) ? 10 : 42;
    endcase
  endfunction

  task automatic checkOut();
    vecCount++;
    if (outValid !== expValid) begin
      failCount++;
      $display("FAIL %s outValid got %0b exp %0b", tag, outValid, expValid);
    end else if (expValid && (outData !== expData || outSof !== expSof || outEol !== expEol)) begin
      failCount++;
      $display("FAIL %s data/sof/eol got %0h/%0b/%0b exp %0h/%0b/%0b",
               tag, outData, outSof, outEol, expData, expSof, expEol);
    end
  endtask

  task automatic modelPush(int pix, bit sof, bit img, int sel);
    int a, b, y, x;
    if (sof) begin mRow = 0; mCol = 0; mMode = img; mThr = 16 >> sel; end
    ring[mRow % 3][mCol] = pix;
    expValid = 0;
    if (mMode != 0) begin
      expValid = 1; expData = pix[PW-1:0];
      expSof = (mRow == 0 && mCol == 0); expEol = (mCol == W - 1);
    end else if (mRow >= 1 && mCol >= 1) begin
      y = mRow - 1; x = mCol - 1;
      expValid = 1; expSof = (y == 0 && x == 0); expEol = (x == W - 2);
      if (y == 0 || x == 0) expData = '0;
      else begin
        a = ring[(y - 1) % 3][x - 1] - ring[(y + 1) % 3][x + 1];
        b = ring[(y - 1) % 3][x + 1] - ring[(y + 1) % 3][x - 1];
        if (a < 0) a = -a;
        if (b < 0) b = -b;
        if (a > 31) a = 31;
        if (b > 31) b = 31;
        expData = (a > mThr || b > mThr) ? 6'd1 : 6'd0;
      end
    end
    mCol++;
    if (mCol == W) begin mCol = 0; mRow++; if (mRow == H) mRow = 0; end
  endtask

  task automatic step(bit v, int pix, bit sof, bit img, int sel);
    @(negedge clk);
    checkOut();
    inValid = v; inPixel = pix[PW-1:0]; inSof = sof; modeImage = img; thrSel = sel[1:0];
    if (v && inReady) modelPush(pix, sof, img, sel);
    else expValid = 0;
  endtask

  task automatic runFrame(int rows, int kind, bit img, int sel, int stallPct, bit jitter);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < W; c++) begin
        int p; bit im; int sl;
        p = pattern(kind, r, c);
        while (stallPct > 0 && (nextRand() % 100) < stallPct)
          step(0, nextRand(), 0, img, sel);
        im = img; sl = sel;
        if (jitter && !(r == 0 && c == 0)) begin im = nextRand() & 1; sl = nextRand() & 3; end
        step(1, p, (r == 0 && c == 0), im, sl);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vecCount++;
    if (outValid !== 1'b0) begin
      failCount++; $display("FAIL R1 outValid in reset got %0b exp 0", outValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    vecCount++;
    if (inReady !== 1'b1) begin
      failCount++; $display("FAIL R1 inReady after reset got %0b exp 1", inReady);
    end
    tag = "R3";  runFrame(3, 3, 1, 0, 20, 0);
    tag = "R5";  runFrame(6, 0, 0, 0, 10, 0);
    tag = "R8";  runFrame(4, 1, 0, 1, 0, 0);   // |A| == 8 == T: no edge
    tag = "R7";  runFrame(4, 1, 0, 2, 0, 0);   // T = 4: edge
    tag = "R6";  runFrame(4, 2, 0, 3, 0, 0);   // only B, T = 2
    runFrame(4, 2, 0, 0, 0, 0);                 // only B, T = 16
    tag = "R9";  runFrame(3, 4, 0, 2, 0, 0);
    tag = "R4";  runFrame(5, 0, 0, 2, 0, 0);
    tag = "R10"; runFrame(5, 0, 0, 1, 5, 1);
    runFrame(3, 3, 1, 0, 0, 1);
    tag = "R2";
    for (int i = 0; i < 50; i++) step(1, nextRand() & 63, (i == 0), 0, 3);
    runFrame(4, 0, 0, 3, 0, 0);
    tag = "R11"; runFrame(H, 0, 0, 0, 2, 0);
    tag = "R2";
    for (int i = 0; i < 3 * W; i++) step(1, nextRand() & 63, 0, 1, 3);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL R11 watchdog got hung run exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end
endmodule